// File: doc/BRIEF.md
# Bit-Serial Dilated Butterfly Switch Node

This block is a single node of a dilated butterfly fabric that moves packets one bit per step in wormhole fashion. It has two input bundles and two output bundles, each made of `EDGES` one-bit edges. Every edge carries a valid/ready stream of beats, and each beat holds one data bit plus a `last` marker. A packet is a run of beats on one edge that ends with the beat whose `last` is set. Every input edge ends in a small queue of `QDEPTH` beats.

When an input edge is not yet connected and a beat reaches the head of its queue, that beat is the routing bit. The switch removes it from the stream. Its value picks output bundle 0 or output bundle 1. The input edge is then connected to a free edge of that bundle, and every later beat of the packet passes through to that edge without being looked at. The connection ends when the `last` beat leaves on the output edge. The switch follows the weak model. In each cycle it looks at no more than one unconnected edge per input bundle, and it makes no more than one new connection.

Back-pressure works as follows. An input beat is taken only in a cycle where `in_valid` and `in_ready` are both high. `in_ready` is low while that edge's queue is full. An output beat is presented with `out_valid` and held unchanged until `out_ready` is seen high. If a routing bit asks for a bundle that has no free edge, the head beat waits in its queue. The plain status output `blocked` is raised for that input bundle, and the queue fills until `in_ready` drops.

Top module: `dilated_bfly_switch`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, every `out_valid` and both `blocked` bits are 0, every `in_ready` is 1, and no edge is connected.
- R2: On an unconnected edge, the first beat is consumed and never forwarded. A value of 0 routes to output edges 0..EDGES-1 (bundle 0), and a value of 1 routes to edges EDGES..2*EDGES-1 (bundle 1). Input edge j belongs to input bundle j/EDGES.
- R3: A new connection takes the lowest-numbered output edge of the chosen bundle that no packet is currently using. Two packets never share an output edge.
- R4: After a connection is made, the remaining beats of the packet appear on the connected output edge in order, with their data and `last` unchanged. Data values do not affect the route. A beat leaves no earlier than the cycle after it entered.
- R5: A presented output beat holds its `out_valid`, `out_data` and `out_last` while `out_ready` is low. An input queue accepts `QDEPTH` beats before `in_ready` drops. No beat is lost or duplicated.
- R6: A connection is released when its `last` beat is taken at the output, and that output edge can be reused by a later packet.
- R7: At most one new connection is made per cycle. When both input bundles can connect in the same cycle, the bundle that was not granted most recently wins, and bundle 0 wins the first such tie after reset.
- R8: Within one input bundle, unconnected edges are examined round-robin. The scan starts at the edge after the one most recently granted or found blocked.
- R9: If the chosen output bundle has no free edge, the head beat stays queued and `blocked[g]` is high for its input bundle g. Once an edge frees, the packet connects and `blocked[g]` clears.
- R10: A packet whose first beat already has `last` set is consumed entirely. No connection is made and nothing is sent out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bit step per cycle |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 2*EDGES | Beat present on each input edge |
| in_data | input | 2*EDGES | Data bit of each input beat |
| in_last | input | 2*EDGES | Final beat of a packet |
| in_ready | output | 2*EDGES | Input edge queue can take a beat |
| out_valid | output | 2*EDGES | Beat present on each output edge |
| out_data | output | 2*EDGES | Data bit of each output beat |
| out_last | output | 2*EDGES | Final beat marker on each output edge |
| out_ready | input | 2*EDGES | Downstream accepts the output beat |
| blocked | output | 2 | Per input bundle: examined head waits for a free edge |

## Verification
The bench goes after several corner cases, and each has a visible failure if the design gets it wrong:
- Simultaneous heads from both input bundles. A fixed-priority arbiter would give bundle 0 the lowest edge even after it had just been served.
- Heads on two edges of one bundle, sent after a previous round. A lowest-index scanner would pick the wrong edge for output 0.
- Routing bits that happen to equal payload bits. A design that forwards the routing bit would show one extra beat on the output.
- A full output bundle. A design that drops or misroutes a blocked head would lose the packet or deliver it on the wrong bundle, and one that never frees connections would leave it waiting forever.
- A header-only packet and a long stall under `out_ready` low. These expose stale connections and beats that change while held.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

  // One beat on a bit-serial edge: payload bit plus end-of-packet marker.
  typedef struct packed {
    logic last;
    logic data;
  } beat_t;

  localparam int BEAT_W = $bits(beat_t);

endpackage

// File: rtl/dbs_edge_fifo.sv
module dbs_edge_fifo #(
  parameter int DEPTH = 2,
  parameter int W     = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_beat,
  output logic         in_ready,
  output logic         out_valid,
  output logic [W-1:0] out_beat,
  input  logic         out_pop
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign in_ready  = (count != CW'(DEPTH));
  assign out_valid = (count != '0);
  assign out_beat  = mem[rd_ptr];
  assign do_push   = in_valid & in_ready;
  assign do_pop    = out_pop & out_valid;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= in_beat;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= step(wr_ptr);
      if (do_pop)  rd_ptr <= step(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/dbs_rr_pick.sv
module dbs_rr_pick #(
  parameter int N  = 4,
  parameter int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  input  logic [PW-1:0] start,
  output logic          found,
  output logic [PW-1:0] idx
);

  // First requester at or after start, wrapping; highest offset scanned
  // first so the nearest one is written last and wins.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int off = N - 1; off >= 0; off--) begin
      int j;
      j = int'(start) + off;
      if (j >= N) j = j - N;
      if (req[j]) begin
        found = 1'b1;
        idx   = PW'(j);
      end
    end
  end

endmodule

// File: rtl/dilated_bfly_switch.sv
module dilated_bfly_switch
  import dbs_pkg::*;
#(
  parameter int EDGES  = 4,
  parameter int QDEPTH = 2
) (
  input  logic [0:0]         clk,
  input  logic [0:0]         rst,
  input  logic [2*EDGES-1:0] in_valid,
  input  logic [2*EDGES-1:0] in_data,
  input  logic [2*EDGES-1:0] in_last,
  output logic [2*EDGES-1:0] in_ready,
  output logic [2*EDGES-1:0] out_valid,
  output logic [2*EDGES-1:0] out_data,
  output logic [2*EDGES-1:0] out_last,
  input  logic [2*EDGES-1:0] out_ready,
  output logic [1:0]         blocked
);

  localparam int NE = 2 * EDGES;
  localparam int IW = $clog2(NE);
  localparam int LW = $clog2(EDGES);

  // Per input edge queue heads
  logic [NE-1:0] q_valid, q_data, q_last, q_pop;

  // Connection tables
  logic [NE-1:0]         ib_bound;
  logic [NE-1:0][IW-1:0] ib_dst;
  logic [NE-1:0]         ob_busy;
  logic [NE-1:0][IW-1:0] ob_src;

  // Arbitration state
  logic                  prio;
  logic [1:0][LW-1:0]    rr_ptr;

  // Scanner and free-edge finder results
  logic [1:0]            cand_found, free_found;
  logic [1:0][LW-1:0]    cand_idx, free_idx;
  logic [1:0][IW-1:0]    cand_pos;
  logic [1:0]            cand_bit, cand_last, routable, stuck;

  logic                  grant_any, gsel, tgt, grant_bind;
  logic [IW-1:0]         grant_in, grant_out;
  logic [NE-1:0]         hdr_pop, data_pop;

  function automatic logic [LW-1:0] next_edge(input logic [LW-1:0] e);
    return (e == LW'(EDGES - 1)) ? '0 : e + 1'b1;
  endfunction

  // ---------------- input edge queues ----------------
  for (genvar i = 0; i < NE; i++) begin : g_inq
    beat_t push_b, head_b;
    assign push_b = '{last: in_last[i], data: in_data[i]};

    dbs_edge_fifo #(.DEPTH(QDEPTH), .W(BEAT_W)) u_q (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid[i]),
      .in_beat   (push_b),
      .in_ready  (in_ready[i]),
      .out_valid (q_valid[i]),
      .out_beat  (head_b),
      .out_pop   (q_pop[i])
    );

    assign q_data[i] = head_b.data;
    assign q_last[i] = head_b.last;
  end

  // ---------------- per-bundle scanners ----------------
  for (genvar g = 0; g < 2; g++) begin : g_bundle
    logic [EDGES-1:0] unbound_req, free_req;
    assign unbound_req = q_valid[g*EDGES +: EDGES] & ~ib_bound[g*EDGES +: EDGES];
    assign free_req    = ~ob_busy[g*EDGES +: EDGES];

    dbs_rr_pick #(.N(EDGES), .PW(LW)) u_scan (
      .req   (unbound_req),
      .start (rr_ptr[g]),
      .found (cand_found[g]),
      .idx   (cand_idx[g])
    );

    dbs_rr_pick #(.N(EDGES), .PW(LW)) u_free (
      .req   (free_req),
      .start (LW'(0)),
      .found (free_found[g]),
      .idx   (free_idx[g])
    );
  end

  // ---------------- connection decision ----------------
  always_comb begin
    for (int g = 0; g < 2; g++) begin
      cand_pos[g]  = IW'(g * EDGES) + IW'(cand_idx[g]);
      cand_bit[g]  = q_data[cand_pos[g]];
      cand_last[g] = q_last[cand_pos[g]];
      routable[g]  = cand_found[g] & (cand_last[g] | free_found[cand_bit[g]]);
      stuck[g]     = cand_found[g] & ~routable[g];
    end
    grant_any  = |routable;
    gsel       = (&routable) ? prio : routable[1];
    grant_in   = cand_pos[gsel];
    tgt        = cand_bit[gsel];
    grant_out  = (tgt ? IW'(EDGES) : IW'(0)) + IW'(free_idx[tgt]);
    grant_bind = grant_any & ~cand_last[gsel];
    hdr_pop    = '0;
    if (grant_any) hdr_pop[grant_in] = 1'b1;
  end

  // ---------------- forwarding ----------------
  always_comb begin
    for (int i = 0; i < NE; i++) begin
      data_pop[i] = ib_bound[i] & q_valid[i] & out_ready[ib_dst[i]];
    end
    for (int o = 0; o < NE; o++) begin
      out_valid[o] = ob_busy[o] & q_valid[ob_src[o]];
      out_data[o]  = q_data[ob_src[o]];
      out_last[o]  = q_last[ob_src[o]];
    end
  end

  assign q_pop   = hdr_pop | data_pop;
  assign blocked = stuck;

  // ---------------- state ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      ib_bound <= '0;
      ib_dst   <= '0;
      ob_busy  <= '0;
      ob_src   <= '0;
      prio     <= 1'b0;
      rr_ptr   <= '0;
    end else begin
      for (int i = 0; i < NE; i++) begin
        if (data_pop[i] && q_last[i]) begin
          ib_bound[i]         <= 1'b0;
          ob_busy[ib_dst[i]]  <= 1'b0;
        end
      end
      if (grant_bind) begin
        ib_bound[grant_in] <= 1'b1;
        ib_dst[grant_in]   <= grant_out;
        ob_busy[grant_out] <= 1'b1;
        ob_src[grant_out]  <= grant_in;
      end
      if (grant_any) prio <= ~gsel;
      for (int g = 0; g < 2; g++) begin
        if (cand_found[g] && (stuck[g] || (grant_any && (int'(gsel) == g)))) begin
          rr_ptr[g] <= next_edge(cand_idx[g]);
        end
      end
    end
  end

endmodule

// File: rtl/dbs_checker.sv
module dbs_checker #(
  parameter int NE = 8,
  parameter int IW = 3
) (
  input logic                  clk,
  input logic                  rst,
  input logic [NE-1:0]         hdr_pop,
  input logic [NE-1:0]         ib_bound,
  input logic [NE-1:0][IW-1:0] ib_dst,
  input logic [NE-1:0]         ob_busy,
  input logic [NE-1:0][IW-1:0] ob_src,
  input logic [NE-1:0]         out_valid,
  input logic [NE-1:0]         out_data,
  input logic [NE-1:0]         out_last,
  input logic [NE-1:0]         out_ready
);

  assert_reset_quiet_R1: assert property (@(posedge clk) rst |=> (out_valid == '0))
    else $error("R1: output valid after reset");

  assert_one_bind_per_step_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hdr_pop))
    else $error("R7: more than one header consumed in a step");

  for (genvar i = 0; i < NE; i++) begin : g_in
    assert_header_from_unbound_R2: assert property (@(posedge clk) disable iff (rst)
      hdr_pop[i] |-> !ib_bound[i])
      else $error("R2: header taken from a connected edge");
  end

  for (genvar o = 0; o < NE; o++) begin : g_out
    assert_link_consistent_R3: assert property (@(posedge clk) disable iff (rst)
      ob_busy[o] |-> (ib_bound[ob_src[o]] && (ib_dst[ob_src[o]] == IW'(o))))
      else $error("R3: output edge table disagrees with input edge table");

    assert_hold_under_stall_R5: assert property (@(posedge clk) disable iff (rst)
      (out_valid[o] && !out_ready[o]) |=>
        (out_valid[o] && $stable(out_data[o]) && $stable(out_last[o])))
      else $error("R5: output beat changed while stalled");
  end

endmodule

bind dilated_bfly_switch dbs_checker #(.NE(NE), .IW(IW)) u_dbs_checker (
  .clk       (clk),
  .rst       (rst),
  .hdr_pop   (hdr_pop),
  .ib_bound  (ib_bound),
  .ib_dst    (ib_dst),
  .ob_busy   (ob_busy),
  .ob_src    (ob_src),
  .out_valid (out_valid),
  .out_data  (out_data),
  .out_last  (out_last),
  .out_ready (out_ready)
);

// File: tb/test_dilated_bfly_switch.sv
module test_dilated_bfly_switch;

  localparam int CLK_PERIOD = 10;
  localparam int B  = 4;
  localparam int NE = 2 * B;
  localparam int LOGN = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NE-1:0] in_valid = '0, in_data = '0, in_last = '0;
  logic [NE-1:0] in_ready, out_valid, out_data, out_last;
  logic [NE-1:0] oready = '1;
  logic [1:0]    blocked;

  int n_checks = 0;
  int n_fail   = 0;

  logic lg_bit [NE][LOGN];
  int   lg_n    [NE];
  int   lg_last [NE];

  always #(CLK_PERIOD / 2) clk = ~clk;

  dilated_bfly_switch #(.EDGES(B), .QDEPTH(2)) i_dilated_bfly_switch (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_last   (in_last),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last),
    .out_ready (oready),
    .blocked   (blocked)
  );

  // Output monitor: samples between edges the values seen at the next edge
  always begin
    @(negedge clk);
    #2;
    for (int o = 0; o < NE; o++) begin
      if (!rst && out_valid[o] && oready[o]) begin
        if (lg_n[o] < LOGN) lg_bit[o][lg_n[o]] = out_data[o];
        if (out_last[o]) lg_last[o] = lg_n[o];
        lg_n[o]++;
      end
    end
  end

  task automatic clear_log();
    for (int o = 0; o < NE; o++) begin
      lg_n[o] = 0;
      lg_last[o] = -1;
    end
  endtask

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_valid = '0;
    oready = '1;
    wait_cycles(3);
    rst = 1'b0;
    clear_log();
  endtask

  task automatic push(int e, logic d, logic l);
    in_valid[e] = 1'b1;
    in_data[e]  = d;
    in_last[e]  = l;
    forever begin
      logic r;
      r = in_ready[e];
      @(negedge clk);
      if (r) break;
    end
    in_valid[e] = 1'b0;
  endtask

  task automatic send_pkt(int e, logic hdr, int len, logic [7:0] p);
    push(e, hdr, len == 0);
    for (int k = 0; k < len; k++) push(e, p[k], k == len - 1);
  endtask

  // Compares the collected stream on output o with payload p of length n
  task automatic check_stream(int o, int n, logic [7:0] p, string req);
    int act;
    act = 0;
    for (int k = 0; k < n && k < 8; k++) act = act | (int'(lg_bit[o][k]) << k);
    chk(lg_n[o] == n, req, $sformatf("beat count on out %0d", o), lg_n[o], n);
    chk(act == int'(p & 8'((1 << n) - 1)), req, $sformatf("payload on out %0d", o),
        act, int'(p & 8'((1 << n) - 1)));
    chk(lg_last[o] == n - 1, req, $sformatf("last position on out %0d", o), lg_last[o], n - 1);
  endtask

  function automatic int total_beats();
    int t;
    t = 0;
    for (int o = 0; o < NE; o++) t += lg_n[o];
    return t;
  endfunction

  typedef struct packed {
    logic [2:0] e;
    logic       h;
    logic [3:0] n;
    logic [7:0] p;
    logic [2:0] o;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{e: 3'd0, h: 1'b0, n: 4'd4, p: 8'b0000_1101, o: 3'd0},
    '{e: 3'd5, h: 1'b0, n: 4'd3, p: 8'b0000_0111, o: 3'd0},
    '{e: 3'd3, h: 1'b1, n: 4'd8, p: 8'b1001_0110, o: 3'd4},
    '{e: 3'd6, h: 1'b1, n: 4'd1, p: 8'b0000_0001, o: 3'd4},
    '{e: 3'd1, h: 1'b0, n: 4'd5, p: 8'b0001_0010, o: 3'd0},
    '{e: 3'd7, h: 1'b1, n: 4'd2, p: 8'b0000_0000, o: 3'd4}
  };

  // Watchdog
  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    clear_log();
    do_reset();

    // R1: reset state
    chk(out_valid == '0, "R1", "out_valid after reset", int'(out_valid), 0);
    chk(in_ready == '1, "R1", "in_ready after reset", int'(in_ready), 255);
    chk(blocked == '0, "R1", "blocked after reset", int'(blocked), 0);

    // Vector table: single packets, R2 routing and R4 pass-through, R6 reuse
    for (int r = 0; r < 6; r++) begin
      clear_log();
      send_pkt(int'(VEC[r].e), VEC[r].h, int'(VEC[r].n), VEC[r].p);
      wait_cycles(8);
      check_stream(int'(VEC[r].o), int'(VEC[r].n), VEC[r].p, "R2 R4 R6");
      chk(total_beats() == int'(VEC[r].n), "R2", "header beat not forwarded",
          total_beats(), int'(VEC[r].n));
    end

    // R7: bundle tie, bundle 0 wins first after reset
    do_reset();
    fork
      send_pkt(0, 1'b0, 2, 8'b01);
      send_pkt(4, 1'b0, 2, 8'b10);
    join
    wait_cycles(8);
    check_stream(0, 2, 8'b01, "R7");
    check_stream(1, 2, 8'b10, "R3 R7");
    // one grant to bundle 0, then a tie goes to bundle 1
    send_pkt(1, 1'b0, 1, 8'b1);
    wait_cycles(8);
    clear_log();
    fork
      send_pkt(0, 1'b0, 2, 8'b01);
      send_pkt(4, 1'b0, 2, 8'b10);
    join
    wait_cycles(8);
    check_stream(0, 2, 8'b10, "R7 rotation");
    check_stream(1, 2, 8'b01, "R7 rotation");

    // R8: round-robin within a bundle
    do_reset();
    fork
      send_pkt(0, 1'b0, 2, 8'b11);
      send_pkt(1, 1'b0, 2, 8'b00);
    join
    wait_cycles(8);
    check_stream(0, 2, 8'b11, "R8");
    check_stream(1, 2, 8'b00, "R8");
    clear_log();
    fork
      send_pkt(1, 1'b0, 2, 8'b01);
      send_pkt(3, 1'b0, 2, 8'b10);
    join
    wait_cycles(8);
    check_stream(0, 2, 8'b10, "R8 scan start");
    check_stream(1, 2, 8'b01, "R8 scan start");

    // R5: back-pressure on output 0
    do_reset();
    oready[0] = 1'b0;
    fork
      send_pkt(0, 1'b0, 6, 8'b0010_1101);
    join_none
    wait_cycles(10);
    chk(in_ready[0] == 1'b0, "R5", "in_ready with full queue", int'(in_ready[0]), 0);
    chk(out_valid[0] == 1'b1, "R5", "out_valid held", int'(out_valid[0]), 1);
    chk(out_data[0] == 1'b1, "R5", "first payload bit held", int'(out_data[0]), 1);
    wait_cycles(3);
    chk(out_valid[0] == 1'b1 && out_data[0] == 1'b1, "R5", "beat still held",
        int'(out_data[0]), 1);
    oready[0] = 1'b1;
    wait fork;
    wait_cycles(10);
    check_stream(0, 6, 8'b0010_1101, "R5");

    // R9: full bundle, blocked head, then R6 reuse of freed edge
    do_reset();
    oready[3:0] = 4'h0;
    fork
      send_pkt(0, 1'b0, 3, 8'b000);
      send_pkt(1, 1'b0, 3, 8'b000);
      send_pkt(2, 1'b0, 3, 8'b000);
      send_pkt(3, 1'b0, 3, 8'b000);
    join_none
    wait_cycles(12);
    chk(out_valid[3:0] == 4'hf, "R3", "all bundle 0 edges connected", int'(out_valid[3:0]), 15);
    fork
      send_pkt(4, 1'b0, 2, 8'b11);
    join_none
    wait_cycles(8);
    chk(blocked == 2'b10, "R9", "blocked while bundle full", int'(blocked), 2);
    chk(out_valid[7:4] == 4'h0, "R9", "no misroute to bundle 1", int'(out_valid[7:4]), 0);
    oready = '1;
    wait fork;
    wait_cycles(10);
    chk(blocked == 2'b00, "R9", "blocked cleared", int'(blocked), 0);
    chk(lg_n[0] == 5, "R6 R9", "beats on freed out 0", lg_n[0], 5);
    chk(lg_bit[0][3] == 1'b1 && lg_bit[0][4] == 1'b1, "R6 R9", "waiting packet on out 0",
        int'({lg_bit[0][4], lg_bit[0][3]}), 3);

    // R10: header-only packet leaves nothing behind
    do_reset();
    send_pkt(2, 1'b1, 0, 8'b0);
    wait_cycles(8);
    chk(total_beats() == 0, "R10", "beats after header-only packet", total_beats(), 0);
    chk(out_valid == '0, "R10", "no output presented", int'(out_valid), 0);
    send_pkt(2, 1'b1, 3, 8'b101);
    wait_cycles(8);
    check_stream(4, 3, 8'b101, "R10");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule